// File: doc/BRIEF.md
# Phase Build-Out Unit for a Digital PLL

This block sits between a phase detector and a loop filter. It absorbs phase steps so that the loop never sees them. It holds a signed offset that it subtracts from every raw phase-error sample. When the reference changes, or the loop is told to begin locking, the block loads the next sample into the offset. The corrected error then restarts at exactly zero, and the output clock takes no phase hit.

A separate, switchable path guards against sudden phase jumps on the reference that is already selected. When two consecutive samples differ by more than a programmable threshold, the jump is folded into the offset. The corrected error then continues from the value it had before the jump.

Every absorption pulses an event flag for one cycle and advances a counter. The phase detector and the loop filter are not part of this block.

Top module: `pbo_buildout_unit`

## Requirements
- R1: A sample accepted while `err_valid` is high appears on `corr_err` with `corr_valid` high after exactly one clock edge. When no build-out occurs, `corr_err` equals `err_in` minus the stored offset.
- R2: A `ref_switch` pulse causes the next accepted sample to be loaded into the offset. That sample's `corr_err` is exactly 0, and later samples are reported relative to it.
- R3: A `lock_entry` pulse causes the same capture as R2.
- R4: Switch or lock pulses that arrive without a sample are held pending until the next accepted sample. Any number of them yields a single capture and a single event. A pulse in the same cycle as a sample applies to that sample.
- R5: With `hit_bo_en` = 1, an accepted sample whose difference from the previous accepted sample has a magnitude strictly greater than `hit_thresh` is a phase hit. The difference is added to the offset, so `corr_err` repeats the previous corrected value.
- R6: A difference whose magnitude equals `hit_thresh` is not a hit, in either direction of step.
- R7: With `hit_bo_en` = 0, phase hits pass to `corr_err` unchanged and raise no event, while R2 and R3 captures still occur.
- R8: `corr_err` saturates at the largest positive or most negative value of its width instead of wrapping. The offset saturates the same way.
- R9: `bo_event` is high for one cycle, together with `corr_valid`, for each capture or hit. `bo_count` advances by one, modulo 2^CNT_W, in that same cycle and holds otherwise.
- R10: After reset the offset, `corr_err`, `corr_valid`, `bo_event` and `bo_count` are zero. The first sample after reset is never a hit, however large it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | Phase-error sample strobe |
| err_in | input | W | Raw signed phase error, one LSB per ns or finer |
| ref_switch | input | 1 | Pulse: the reference has been switched |
| lock_entry | input | 1 | Pulse: locked operation is being entered |
| hit_thresh | input | W | Unsigned step threshold for hit detection |
| hit_bo_en | input | 1 | Enables build-out of hits on the selected reference |
| corr_valid | output | 1 | Corrected sample strobe |
| corr_err | output | W | Corrected signed phase error |
| bo_event | output | 1 | One-cycle build-out event flag |
| bo_count | output | CNT_W | Count of build-out events |

## Verification
The bench places steps exactly at the threshold and one count above it, in both directions. A strict-versus-inclusive compare mistake would therefore absorb a legitimate step or let a hit through.

It issues switch and lock pulses in idle cycles before any sample arrives. A design that dropped pending requests would report the old offset; one that counted each pulse would report several events. It also sends a huge first sample after reset, which a design lacking the "no previous sample" guard would treat as a hit.

Extreme values near both rails, combined with a nonzero offset, expose any wraparound in the subtraction. A disabled hit path followed by a switch shows that the enable gates only hits.

// File: rtl/pbo_pkg.sv
package pbo_pkg;
   typedef enum logic [1:0] {
      BO_NONE    = 2'd0,
      BO_CAPTURE = 2'd1,
      BO_HIT     = 2'd2
   } bo_cause_e;
endpackage

// File: rtl/pbo_sat_sum.sv
// Signed sum of two W+1 bit operands reduced to W bits, saturating or wrapping.
module pbo_sat_sum #(
   parameter int W        = 24,
   parameter bit SATURATE = 1'b1
) (
   input  logic signed [W:0]   a_i,
   input  logic signed [W:0]   b_i,
   output logic signed [W-1:0] y_o
);
   localparam logic signed [W+1:0] HI = {3'b000, {(W-1){1'b1}}};
   localparam logic signed [W+1:0] LO = {3'b111, {(W-1){1'b0}}};

   logic signed [W+1:0] sum;
   assign sum = {a_i[W], a_i} + {b_i[W], b_i};

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (sum > HI)      y_o = HI[W-1:0];
            else if (sum < LO) y_o = LO[W-1:0];
            else               y_o = sum[W-1:0];
         end
      end else begin : g_wrap
         assign y_o = sum[W-1:0];
      end
   endgenerate
endmodule

// File: rtl/pbo_hit_detect.sv
// Flags a step between consecutive samples whose magnitude exceeds the threshold.
module pbo_hit_detect #(
   parameter int W = 24
) (
   input  logic signed [W-1:0] err_i,
   input  logic signed [W-1:0] prev_i,
   input  logic                prev_ok_i,
   input  logic                en_i,
   input  logic        [W-1:0] thr_i,
   output logic                hit_o,
   output logic signed [W:0]   delta_o
);
   logic [W:0] mag;

   assign delta_o = {err_i[W-1], err_i} - {prev_i[W-1], prev_i};
   assign mag     = delta_o[W] ? $unsigned(-delta_o) : $unsigned(delta_o);
   assign hit_o   = prev_ok_i & en_i & (mag > {1'b0, thr_i});
endmodule

// File: rtl/pbo_offset_ctl.sv
// Holds the offset, the previous sample and pending capture requests.
module pbo_offset_ctl
   import pbo_pkg::*;
#(
   parameter int W        = 24,
   parameter bit SATURATE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                err_valid_i,
   input  logic signed [W-1:0] err_i,
   input  logic                switch_i,
   input  logic                lock_i,
   input  logic        [W-1:0] thr_i,
   input  logic                hit_en_i,
   output logic signed [W-1:0] offset_nxt_o,
   output bo_cause_e           cause_o,
   output logic                pend_o
);
   logic signed [W-1:0] offset_q;
   logic signed [W-1:0] prev_q;
   logic                prev_ok_q;
   logic                pend_q;
   logic                hit;
   logic signed [W:0]   delta;
   logic signed [W-1:0] offset_hit;
   logic                want_cap;

   pbo_hit_detect #(.W(W)) hit_i (
      .err_i     (err_i),
      .prev_i    (prev_q),
      .prev_ok_i (prev_ok_q),
      .en_i      (hit_en_i),
      .thr_i     (thr_i),
      .hit_o     (hit),
      .delta_o   (delta)
   );

   pbo_sat_sum #(.W(W), .SATURATE(SATURATE)) addoff_i (
      .a_i ({offset_q[W-1], offset_q}),
      .b_i (delta),
      .y_o (offset_hit)
   );

   assign want_cap = pend_q | switch_i | lock_i;

   always_comb begin
      cause_o      = BO_NONE;
      offset_nxt_o = offset_q;
      if (err_valid_i) begin
         if (want_cap) begin
            cause_o      = BO_CAPTURE;
            offset_nxt_o = err_i;
         end else if (hit) begin
            cause_o      = BO_HIT;
            offset_nxt_o = offset_hit;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         offset_q  <= '0;
         prev_q    <= '0;
         prev_ok_q <= 1'b0;
         pend_q    <= 1'b0;
      end else if (err_valid_i) begin
         offset_q  <= offset_nxt_o;
         prev_q    <= err_i;
         prev_ok_q <= 1'b1;
         pend_q    <= 1'b0;
      end else begin
         pend_q    <= want_cap;
      end
   end

   assign pend_o = pend_q;
endmodule

// File: rtl/pbo_event_cnt.sv
// Wrapping event counter.
module pbo_event_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   output logic [CNT_W-1:0] count_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     count_o <= '0;
      else if (inc_i) count_o <= count_o + 1'b1;
   end
endmodule

// File: rtl/pbo_buildout_unit.sv
module pbo_buildout_unit
   import pbo_pkg::*;
#(
   parameter int W        = 24,
   parameter int CNT_W    = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                err_valid,
   input  logic signed [W-1:0] err_in,
   input  logic                ref_switch,
   input  logic                lock_entry,
   input  logic        [W-1:0] hit_thresh,
   input  logic                hit_bo_en,
   output logic                corr_valid,
   output logic signed [W-1:0] corr_err,
   output logic                bo_event,
   output logic [CNT_W-1:0]    bo_count
);
   generate
      if (W < 4 || W > 30) begin : g_bad_w
         $error("pbo_buildout_unit: W out of range");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("pbo_buildout_unit: CNT_W out of range");
      end
   endgenerate

   logic signed [W-1:0] offset_nxt;
   bo_cause_e           cause;
   logic                cap_pend;
   logic signed [W:0]   neg_off;
   logic signed [W-1:0] corr_nxt;

   pbo_offset_ctl #(.W(W), .SATURATE(SATURATE)) ctl_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .err_valid_i  (err_valid),
      .err_i        (err_in),
      .switch_i     (ref_switch),
      .lock_i       (lock_entry),
      .thr_i        (hit_thresh),
      .hit_en_i     (hit_bo_en),
      .offset_nxt_o (offset_nxt),
      .cause_o      (cause),
      .pend_o       (cap_pend)
   );

   assign neg_off = -{offset_nxt[W-1], offset_nxt};

   pbo_sat_sum #(.W(W), .SATURATE(SATURATE)) sub_i (
      .a_i ({err_in[W-1], err_in}),
      .b_i (neg_off),
      .y_o (corr_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         corr_valid <= 1'b0;
         corr_err   <= '0;
         bo_event   <= 1'b0;
      end else begin
         corr_valid <= err_valid;
         bo_event   <= (cause != BO_NONE);
         if (err_valid) corr_err <= corr_nxt;
      end
   end

   pbo_event_cnt #(.CNT_W(CNT_W)) cnt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .inc_i   (cause != BO_NONE),
      .count_o (bo_count)
   );
endmodule

// File: rtl/pbo_buildout_chk.sv
module pbo_buildout_chk #(
   parameter int W     = 24,
   parameter int CNT_W = 16
) (
   input logic                clk,
   input logic                rst_n,
   input logic                err_valid,
   input logic                ref_switch,
   input logic                lock_entry,
   input logic                hit_bo_en,
   input logic                pend,
   input logic                corr_valid,
   input logic signed [W-1:0] corr_err,
   input logic                bo_event,
   input logic [CNT_W-1:0]    bo_count
);
   p_valid_lat_r1: assert property (@(posedge clk) disable iff (!rst_n)
      corr_valid == $past(err_valid));

   p_capture_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(err_valid && (ref_switch || lock_entry || pend)) |-> (corr_err == '0 && bo_event));

   p_event_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bo_event |-> corr_valid);

   p_cnt_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bo_event |-> bo_count == CNT_W'($past(bo_count) + 1'b1));

   p_cnt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !bo_event |-> $stable(bo_count));

   p_no_hit_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(err_valid && !hit_bo_en && !ref_switch && !lock_entry && !pend) |-> !bo_event);

   p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(err_valid) |-> !bo_event);
endmodule

bind pbo_buildout_unit pbo_buildout_chk #(.W(W), .CNT_W(CNT_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .err_valid  (err_valid),
   .ref_switch (ref_switch),
   .lock_entry (lock_entry),
   .hit_bo_en  (hit_bo_en),
   .pend       (cap_pend),
   .corr_valid (corr_valid),
   .corr_err   (corr_err),
   .bo_event   (bo_event),
   .bo_count   (bo_count)
);

// File: tb/pbo_buildout_unit_tb_top.sv
`timescale 1ns/1ps
module pbo_buildout_unit_tb_top;
   localparam int W     = 24;
   localparam int CNT_W = 16;
   localparam longint MAXV = (64'sd1 <<< (W-1)) - 1;
   localparam longint MINV = -(64'sd1 <<< (W-1));

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                err_valid = 1'b0;
   logic signed [W-1:0] err_in = '0;
   logic                ref_switch = 1'b0;
   logic                lock_entry = 1'b0;
   logic        [W-1:0] hit_thresh = '0;
   logic                hit_bo_en = 1'b0;
   logic                corr_valid;
   logic signed [W-1:0] corr_err;
   logic                bo_event;
   logic [CNT_W-1:0]    bo_count;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // reference model state
   longint m_off, m_prev, m_corr, m_cnt;
   bit     m_prev_ok, m_pend;

   always #2 clk = ~clk;

   pbo_buildout_unit #(.W(W), .CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .err_valid(err_valid), .err_in(err_in),
      .ref_switch(ref_switch), .lock_entry(lock_entry), .hit_thresh(hit_thresh),
      .hit_bo_en(hit_bo_en), .corr_valid(corr_valid), .corr_err(corr_err),
      .bo_event(bo_event), .bo_count(bo_count)
   );

   function automatic longint clamp(input longint v);
      if (v > MAXV) return MAXV;
      if (v < MINV) return MINV;
      return v;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // One stimulus cycle; compares every output against the model.
   task automatic send(input longint e, input bit sw, input bit lk, input bit v,
                       input string req);
      bit cap, hit, ev;
      longint d, ad;
      @(negedge clk);
      err_valid = v; err_in = W'(e); ref_switch = sw; lock_entry = lk;
      ev = 1'b0;
      if (v) begin
         cap = m_pend | sw | lk;
         d   = e - m_prev;
         ad  = (d < 0) ? -d : d;
         hit = !cap && m_prev_ok && hit_bo_en && (ad > longint'(hit_thresh));
         if (cap)      m_off = e;
         else if (hit) m_off = clamp(m_off + d);
         m_corr = clamp(e - m_off);
         ev = cap | hit;
         m_prev = e; m_prev_ok = 1'b1; m_pend = 1'b0;
         if (ev) m_cnt = (m_cnt + 1) % (64'sd1 <<< CNT_W);
      end else begin
         m_pend = m_pend | sw | lk;
      end
      @(posedge clk); #1;
      check(corr_valid === v, req, "corr_valid", longint'(corr_valid), longint'(v));
      if (v) check(longint'(corr_err) == m_corr, req, "corr_err", longint'(corr_err), m_corr);
      check(bo_event === ev, req, "bo_event", longint'(bo_event), longint'(ev));
      check(longint'(bo_count) == m_cnt, req, "bo_count", longint'(bo_count), m_cnt);
      @(negedge clk);
      err_valid = 1'b0; ref_switch = 1'b0; lock_entry = 1'b0;
   endtask

   task automatic t_reset_r10();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      m_off = 0; m_prev = 0; m_corr = 0; m_cnt = 0; m_prev_ok = 0; m_pend = 0;
      check(corr_valid === 1'b0 && bo_event === 1'b0, "R10", "flags after reset",
            longint'({corr_valid, bo_event}), 0);
      check(corr_err === '0, "R10", "corr_err after reset", longint'(corr_err), 0);
      check(bo_count === '0, "R10", "bo_count after reset", longint'(bo_count), 0);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_first_sample_r10();
      hit_bo_en = 1'b1; hit_thresh = 0;
      send(5000, 0, 0, 1, "R10");      // no previous sample: not a hit
      send(5000, 0, 0, 1, "R1");
      send(-321, 0, 0, 1, "R5");       // real hit
   endtask

   task automatic t_passthrough_r1();
      hit_bo_en = 1'b0;
      send(17, 0, 0, 1, "R1");
      send(-4000, 0, 0, 1, "R1");
      send(0, 0, 0, 0, "R1");
      send(123456, 0, 0, 1, "R1");
   endtask

   task automatic t_switch_r2();
      hit_bo_en = 1'b0;
      send(777, 1, 0, 1, "R2");        // capture: corr 0
      send(790, 0, 0, 1, "R2");        // relative: 13
      send(700, 0, 0, 1, "R2");
   endtask

   task automatic t_lock_r3();
      hit_bo_en = 1'b1; hit_thresh = 1000;
      send(-2500, 0, 1, 1, "R3");
      send(-2490, 0, 0, 1, "R3");
   endtask

   task automatic t_pending_r4();
      hit_bo_en = 1'b0;
      send(0, 1, 0, 0, "R4");
      send(0, 0, 1, 0, "R4");
      send(0, 1, 1, 0, "R4");
      send(300, 0, 0, 1, "R4");        // single capture, single event
      send(310, 0, 0, 1, "R4");        // no leftover request
   endtask

   task automatic t_hit_r5_r6();
      hit_bo_en = 1'b1; hit_thresh = 50;
      send(10, 1, 0, 1, "R5");
      send(20, 0, 0, 1, "R5");
      send(200, 0, 0, 1, "R5");        // +180 step absorbed
      send(210, 0, 0, 1, "R5");
      send(260, 0, 0, 1, "R6");        // step == threshold
      send(210, 0, 0, 1, "R6");        // -50 == threshold
      send(261, 0, 0, 1, "R6");        // +51 above threshold
      send(100, 0, 0, 1, "R5");        // negative hit
   endtask

   task automatic t_disabled_r7();
      hit_bo_en = 1'b0; hit_thresh = 10;
      send(0, 1, 0, 1, "R7");
      send(500, 0, 0, 1, "R7");        // hit passes through
      send(-900, 0, 0, 1, "R7");
      send(700, 1, 0, 1, "R7");        // switch still captures
   endtask

   task automatic t_saturate_r8();
      hit_bo_en = 1'b0;
      send(-100, 1, 0, 1, "R8");
      send(MAXV, 0, 0, 1, "R8");       // MAX+100 clamps
      send(MINV, 0, 0, 1, "R8");
      send(100, 0, 1, 1, "R8");
      send(MINV, 0, 0, 1, "R8");       // MIN-100 clamps
      hit_bo_en = 1'b1; hit_thresh = 0;
      send(MAXV, 0, 0, 1, "R8");       // offset saturates on absorb
      send(MAXV - 5, 0, 0, 1, "R8");
   endtask

   task automatic t_count_r9();
      hit_bo_en = 1'b1; hit_thresh = 5;
      for (int i = 0; i < 6; i++) send(longint'(i) * 40, (i % 3) == 0, 0, 1, "R9");
      send(0, 0, 0, 0, "R9");
   endtask

   initial begin
      t_reset_r10();
      t_first_sample_r10();
      t_passthrough_r1();
      t_switch_r2();
      t_lock_r3();
      t_pending_r4();
      t_hit_r5_r6();
      t_disabled_r7();
      t_saturate_r8();
      t_count_r9();
      t_reset_r10();
      send(42, 0, 0, 1, "R10");
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog all-requirements actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule